// File: doc/BRIEF.md
# Next-PC and Control-Flow Timing Unit

This unit works out where the program counter goes after a control-flow instruction and how many clock cycles that instruction costs. Decode gives it one instruction per valid strobe. The strobe carries the current word address, an instruction class, a signed word offset, a status-bit selector, the status register, the Z pointer, the result of a skip test, a flag for a two-word follower and the address popped from the stack. One cycle later the unit presents the next PC and a redirect indication. It also presents the cycle cost, the link address for a call and, for an interrupt return, a request to turn interrupts back on.

Relative jumps, calls and taken branches move to PC + offset + 1. The offset is sign-extended, and the sum wraps within the program memory. Indirect forms take the low bits of the Z pointer. Returns take the popped address. A conditional branch picks one status bit and jumps if that bit matches the wanted polarity. Selector 4 is the signed-compare case: it tests the exclusive-OR of the negative and overflow flags, not a stored copy. A skip steps over the next instruction, which may be one word or two words long. Fetch, decode and the stack memory belong to the surrounding core.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the registered outputs become `out_valid`=0, `pc_next`=0, `redirect`=0, `cyc_count`=0, `ret_addr`=0 and `set_ie`=0.
- R2: `out_valid` is high exactly in the cycle after a cycle with `ins_valid` high. After an idle cycle, `redirect` and `set_ie` are 0, and `pc_next`, `cyc_count` and `ret_addr` keep their values.
- R3: Class 1 (relative jump, 2 cycles) and class 3 (relative call, 3 cycles) give `pc_next` = (`pc_now` + sign-extended `rel_ofs` + 1) mod 2^PC_W.
- R4: Class 2 (indirect jump, 2 cycles) and class 4 (indirect call, 3 cycles) give `pc_next` = the low PC_W bits of `zptr`.
- R5: Every accepted instruction sets `ret_addr` = (`pc_now` + 1) mod 2^PC_W, so a call has its link address ready to push.
- R6: Class 5 (return) and class 6 (interrupt return) give `pc_next` = `stack_pc` in 4 cycles. `set_ie` is 1 only after class 6.
- R7: Class 7 branches when the selected effective status bit is 1, and class 8 branches when it is 0. The selector `bit_sel` uses this bit order: C=0, Z=1, N=2, V=3, signed=4, H=5, T=6, I=7. A taken branch gives `pc_next` = PC + offset + 1 in 2 cycles. A branch not taken gives `pc_next` = `pc_now` + 1 in 1 cycle.
- R8: The effective bit at selector 4 is `sreg[2]` XOR `sreg[3]`. Stored bit `sreg[4]` has no effect.
- R9: In class 9 (skip), `skip_cond`=0 gives `pc_now` + 1 in 1 cycle. `skip_cond`=1 gives `pc_now` + 2 in 2 cycles, or `pc_now` + 3 in 3 cycles when `next_is_long`=1. All results wrap mod 2^PC_W.
- R10: Class 0 and the unused codes 10 to 15 give `pc_now` + 1 in 1 cycle, with no redirect.
- R11: `redirect` is 1 for classes 1 to 6, for a taken branch and for a skip that is performed, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | An instruction is presented this cycle |
| ins_class | input | 4 | Control-flow class code |
| pc_now | input | PC_W | Word address of the current instruction |
| rel_ofs | input | OFS_W | Signed word offset |
| bit_sel | input | 3 | Status-bit selector for branches |
| sreg | input | 8 | Status register |
| zptr | input | Z_W | Z pointer for indirect forms |
| skip_cond | input | 1 | The skip test holds |
| next_is_long | input | 1 | The following instruction is two words long |
| stack_pc | input | PC_W | Address popped from the stack |
| out_valid | output | 1 | Results below belong to the previous accepted instruction |
| pc_next | output | PC_W | Next program counter |
| redirect | output | 1 | Flow leaves the straight-line path |
| cyc_count | output | 3 | Cycles consumed by the instruction |
| ret_addr | output | PC_W | Link address PC + 1 |
| set_ie | output | 1 | Request to set the interrupt-enable flag |

## Verification
An interrupt return does two things in the same output cycle: it loads the PC from the popped address and it raises the interrupt-enable request. A dropped or mistimed half of that pair is the likely fault. The bench sends interrupt returns back to back and mixed with plain returns, each with a different popped address. It compares `pc_next`, `cyc_count` and `set_ie` together against the reference model in that one cycle. A performed skip with a two-word follower near the top of memory is also run, so that the three-word step and the address wrap happen in the same cycle.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [3:0] {
        FC_SEQ   = 4'd0,
        FC_RJMP  = 4'd1,
        FC_IJMP  = 4'd2,
        FC_RCALL = 4'd3,
        FC_ICALL = 4'd4,
        FC_RET   = 4'd5,
        FC_RETI  = 4'd6,
        FC_BSET  = 4'd7,
        FC_BCLR  = 4'd8,
        FC_SKIP  = 4'd9
    } flow_class_e;

    typedef enum logic [1:0] {
        TGT_STEP,
        TGT_REL,
        TGT_ZPTR,
        TGT_STACK
    } tgt_sel_e;

    typedef struct packed {
        logic       redirect;
        logic [2:0] cycles;
        logic       set_ie;
    } flow_res_t;

    localparam int SB_NEG  = 2;
    localparam int SB_OVF  = 3;
    localparam int SB_SIGN = 4;
    localparam int SREG_W  = 8;

    localparam logic [2:0] CYC_SEQ  = 3'd1;
    localparam logic [2:0] CYC_JMP  = 3'd2;
    localparam logic [2:0] CYC_CALL = 3'd3;
    localparam logic [2:0] CYC_RET  = 3'd4;

    function automatic flow_class_e decode_class(input logic [3:0] raw);
        if (raw > 4'd9)
            return FC_SEQ;
        return flow_class_e'(raw);
    endfunction

endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
    import npc_pkg::*;
(
    input  flow_class_e        cls,
    input  logic [2:0]         bit_sel,
    input  logic [SREG_W-1:0]  sreg,
    input  logic               skip_cond,
    output logic               taken
);

    logic [SREG_W-1:0] eff_bits;
    logic              stored_sign_unused;

    assign stored_sign_unused = sreg[SB_SIGN];

    for (genvar i = 0; i < SREG_W; i++) begin : g_eff
        if (i == SB_SIGN) begin : g_signed
            assign eff_bits[i] = sreg[SB_NEG] ^ sreg[SB_OVF];
        end else begin : g_plain
            assign eff_bits[i] = sreg[i];
        end
    end

    always_comb begin
        case (cls)
            FC_BSET: taken = eff_bits[bit_sel];
            FC_BCLR: taken = ~eff_bits[bit_sel];
            FC_SKIP: taken = skip_cond;
            default: taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_flow_ctl.sv
module npc_flow_ctl
    import npc_pkg::*;
(
    input  flow_class_e cls,
    input  logic        taken,
    input  logic        next_long,
    output tgt_sel_e    sel,
    output logic [1:0]  step,
    output flow_res_t   res
);

    always_comb begin
        sel  = TGT_STEP;
        step = 2'd1;
        res  = '{redirect: 1'b0, cycles: CYC_SEQ, set_ie: 1'b0};
        case (cls)
            FC_RJMP: begin
                sel = TGT_REL;
                res = '{redirect: 1'b1, cycles: CYC_JMP, set_ie: 1'b0};
            end
            FC_IJMP: begin
                sel = TGT_ZPTR;
                res = '{redirect: 1'b1, cycles: CYC_JMP, set_ie: 1'b0};
            end
            FC_RCALL: begin
                sel = TGT_REL;
                res = '{redirect: 1'b1, cycles: CYC_CALL, set_ie: 1'b0};
            end
            FC_ICALL: begin
                sel = TGT_ZPTR;
                res = '{redirect: 1'b1, cycles: CYC_CALL, set_ie: 1'b0};
            end
            FC_RET: begin
                sel = TGT_STACK;
                res = '{redirect: 1'b1, cycles: CYC_RET, set_ie: 1'b0};
            end
            FC_RETI: begin
                sel = TGT_STACK;
                res = '{redirect: 1'b1, cycles: CYC_RET, set_ie: 1'b1};
            end
            FC_BSET, FC_BCLR: begin
                if (taken) begin
                    sel = TGT_REL;
                    res = '{redirect: 1'b1, cycles: CYC_JMP, set_ie: 1'b0};
                end
            end
            FC_SKIP: begin
                if (taken) begin
                    step = next_long ? 2'd3 : 2'd2;
                    res  = '{redirect: 1'b1,
                             cycles: next_long ? CYC_CALL : CYC_JMP,
                             set_ie: 1'b0};
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/npc_target_calc.sv
module npc_target_calc
    import npc_pkg::*;
#(
    parameter int PC_W  = 11,
    parameter int OFS_W = 12,
    parameter int Z_W   = 16
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFS_W-1:0] ofs,
    input  logic [Z_W-1:0]   zptr,
    input  logic [PC_W-1:0]  stack_pc,
    input  tgt_sel_e         sel,
    input  logic [1:0]       step,
    output logic [PC_W-1:0]  tgt,
    output logic [PC_W-1:0]  link
);

    localparam int SUM_W = PC_W + OFS_W;

    logic [SUM_W-1:0]       rel_sum;
    logic [SUM_W-PC_W-1:0]  rel_hi_unused;
    logic [PC_W-1:0]        rel_tgt;
    logic [PC_W-1:0]        z_tgt;
    logic [PC_W-1:0]        step_tgt;

    assign rel_sum       = SUM_W'(pc) + {{PC_W{ofs[OFS_W-1]}}, ofs} + SUM_W'(1);
    assign rel_hi_unused = rel_sum[SUM_W-1:PC_W];
    assign rel_tgt       = rel_sum[PC_W-1:0];

    if (Z_W >= PC_W) begin : g_ztrunc
        assign z_tgt = zptr[PC_W-1:0];
        if (Z_W > PC_W) begin : g_zhi
            logic [Z_W-PC_W-1:0] zhi_unused;
            assign zhi_unused = zptr[Z_W-1:PC_W];
        end
    end else begin : g_zext
        assign z_tgt = PC_W'(zptr);
    end

    assign step_tgt = pc + PC_W'(step);
    assign link     = pc + PC_W'(1);

    always_comb begin
        case (sel)
            TGT_REL:   tgt = rel_tgt;
            TGT_ZPTR:  tgt = z_tgt;
            TGT_STACK: tgt = stack_pc;
            default:   tgt = step_tgt;
        endcase
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int PC_W  = 11,
    parameter int OFS_W = 12,
    parameter int Z_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    input  logic [3:0]        ins_class,
    input  logic [PC_W-1:0]   pc_now,
    input  logic [OFS_W-1:0]  rel_ofs,
    input  logic [2:0]        bit_sel,
    input  logic [7:0]        sreg,
    input  logic [Z_W-1:0]    zptr,
    input  logic              skip_cond,
    input  logic              next_is_long,
    input  logic [PC_W-1:0]   stack_pc,
    output logic              out_valid,
    output logic [PC_W-1:0]   pc_next,
    output logic              redirect,
    output logic [2:0]        cyc_count,
    output logic [PC_W-1:0]   ret_addr,
    output logic              set_ie
);

    flow_class_e      cls;
    logic             taken;
    tgt_sel_e         sel;
    logic [1:0]       step;
    flow_res_t        res;
    logic [PC_W-1:0]  tgt;
    logic [PC_W-1:0]  link;

    assign cls = decode_class(ins_class);

    npc_cond_eval i_cond (
        .cls       (cls),
        .bit_sel   (bit_sel),
        .sreg      (sreg),
        .skip_cond (skip_cond),
        .taken     (taken)
    );

    npc_flow_ctl i_ctl (
        .cls       (cls),
        .taken     (taken),
        .next_long (next_is_long),
        .sel       (sel),
        .step      (step),
        .res       (res)
    );

    npc_target_calc #(
        .PC_W  (PC_W),
        .OFS_W (OFS_W),
        .Z_W   (Z_W)
    ) i_tgt (
        .pc       (pc_now),
        .ofs      (rel_ofs),
        .zptr     (zptr),
        .stack_pc (stack_pc),
        .sel      (sel),
        .step     (step),
        .tgt      (tgt),
        .link     (link)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            pc_next   <= '0;
            redirect  <= 1'b0;
            cyc_count <= '0;
            ret_addr  <= '0;
            set_ie    <= 1'b0;
        end else if (ins_valid) begin
            out_valid <= 1'b1;
            pc_next   <= tgt;
            redirect  <= res.redirect;
            cyc_count <= res.cycles;
            ret_addr  <= link;
            set_ie    <= res.set_ie;
        end else begin
            out_valid <= 1'b0;
            redirect  <= 1'b0;
            set_ie    <= 1'b0;
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        ins_valid |=> out_valid); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ins_valid |=> (!out_valid && !set_ie && !redirect && $stable(pc_next))); // R2

    AST_RETI_PAIR: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && ins_class == 4'd6) |=>
            (set_ie && redirect && pc_next == $past(stack_pc) && cyc_count == 3'd4)); // R6

    AST_IE_ONLY_RETI: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && ins_class != 4'd6) |=> !set_ie); // R6

    AST_CALL_LINK: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && (ins_class == 4'd3 || ins_class == 4'd4)) |=>
            (ret_addr == $past(pc_now) + PC_W'(1) && cyc_count == 3'd3)); // R5

    AST_STRAIGHT_ONE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !redirect) |-> (cyc_count == 3'd1)); // R7

    AST_CYC_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (cyc_count >= 3'd1 && cyc_count <= 3'd4)); // R3

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && (ins_class == 4'd0 || ins_class > 4'd9)) |=>
            (!redirect && pc_next == $past(pc_now) + PC_W'(1))); // R10

endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;

    localparam int PC_W  = 11;
    localparam int OFS_W = 12;
    localparam int Z_W   = 16;
    localparam int MASK  = (1 << PC_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ins_valid = 1'b0;
    logic [3:0]        ins_class = '0;
    logic [PC_W-1:0]   pc_now = '0;
    logic [OFS_W-1:0]  rel_ofs = '0;
    logic [2:0]        bit_sel = '0;
    logic [7:0]        sreg = '0;
    logic [Z_W-1:0]    zptr = '0;
    logic              skip_cond = 1'b0;
    logic              next_is_long = 1'b0;
    logic [PC_W-1:0]   stack_pc = '0;
    logic              out_valid;
    logic [PC_W-1:0]   pc_next;
    logic              redirect;
    logic [2:0]        cyc_count;
    logic [PC_W-1:0]   ret_addr;
    logic              set_ie;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    int  e_valid, e_pc, e_redir, e_cyc, e_ret, e_ie;
    int  last_cls, last_bs;
    bit  last_v;
    bit  in_reset;

    always #10 clk = ~clk;

    npc_unit #(.PC_W(PC_W), .OFS_W(OFS_W), .Z_W(Z_W)) i_npc_unit (
        .clk, .rst, .ins_valid, .ins_class, .pc_now, .rel_ofs, .bit_sel,
        .sreg, .zptr, .skip_cond, .next_is_long, .stack_pc,
        .out_valid, .pc_next, .redirect, .cyc_count, .ret_addr, .set_ie
    );

    function automatic string req_tag();
        if (in_reset) return "R1";
        if (!last_v) return "R2";
        case (last_cls)
            1, 3: return "R3";
            2, 4: return "R4";
            5, 6: return "R6";
            7, 8: return (last_bs == 4) ? "R8" : "R7";
            9:    return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        chk(in_reset ? "R1" : "R2", "out_valid", int'(out_valid), e_valid);
        chk(req_tag(), "pc_next", int'(pc_next), e_pc);
        chk(req_tag(), "cyc_count", int'(cyc_count), e_cyc);
        chk(in_reset ? "R1" : "R11", "redirect", int'(redirect), e_redir);
        chk(in_reset ? "R1" : "R5", "ret_addr", int'(ret_addr), e_ret);
        chk(in_reset ? "R1" : "R6", "set_ie", int'(set_ie), e_ie);
    endtask

    // Reference model: expected outputs after the next clock edge.
    task automatic model(input bit v, input int cls, input int p, input int k,
                         input int bs, input logic [7:0] sr, input int z,
                         input bit sk, input bit lg, input int st);
        int  eff;
        bit  tk;
        last_v = v; last_cls = cls; last_bs = bs;
        if (!v) begin
            e_valid = 0; e_redir = 0; e_ie = 0;
            return;
        end
        e_valid = 1;
        e_ie    = 0;
        e_ret   = (p + 1) & MASK;
        eff = (bs == 4) ? int'(sr[2] ^ sr[3]) : int'(sr[bs]);
        case (cls)
            1: begin e_pc = (p + k + 1) & MASK; e_cyc = 2; e_redir = 1; end
            3: begin e_pc = (p + k + 1) & MASK; e_cyc = 3; e_redir = 1; end
            2: begin e_pc = z & MASK; e_cyc = 2; e_redir = 1; end
            4: begin e_pc = z & MASK; e_cyc = 3; e_redir = 1; end
            5: begin e_pc = st; e_cyc = 4; e_redir = 1; end
            6: begin e_pc = st; e_cyc = 4; e_redir = 1; e_ie = 1; end
            7, 8: begin
                tk = (cls == 7) ? (eff == 1) : (eff == 0);
                if (tk) begin e_pc = (p + k + 1) & MASK; e_cyc = 2; e_redir = 1; end
                else    begin e_pc = (p + 1) & MASK;     e_cyc = 1; e_redir = 0; end
            end
            9: begin
                if (!sk)     begin e_pc = (p + 1) & MASK; e_cyc = 1; e_redir = 0; end
                else if (lg) begin e_pc = (p + 3) & MASK; e_cyc = 3; e_redir = 1; end
                else         begin e_pc = (p + 2) & MASK; e_cyc = 2; e_redir = 1; end
            end
            default: begin e_pc = (p + 1) & MASK; e_cyc = 1; e_redir = 0; end
        endcase
    endtask

    task automatic issue(input bit v, input int cls, input int p, input int k,
                         input int bs, input logic [7:0] sr, input int z,
                         input bit sk, input bit lg, input int st);
        @(negedge clk);
        check_all();
        ins_valid    = v;
        ins_class    = 4'(cls);
        pc_now       = PC_W'(p);
        rel_ofs      = OFS_W'(k);
        bit_sel      = 3'(bs);
        sreg         = sr;
        zptr         = Z_W'(z);
        skip_cond    = sk;
        next_is_long = lg;
        stack_pc     = PC_W'(st);
        model(v, cls, p, k, bs, sr, z, sk, lg, st);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        in_reset = 1'b1;
        e_valid = 0; e_pc = 0; e_redir = 0; e_cyc = 0; e_ret = 0; e_ie = 0;
        last_v = 0; last_cls = 0; last_bs = 0;
        repeat (3) @(negedge clk);
        check_all();                         // R1 reset state
        rst = 1'b0;
        in_reset = 1'b0;

        // R3 relative jump and call, wrap both ways
        issue(1, 1, 100, 20, 0, 8'h00, 0, 0, 0, 0);
        issue(1, 1, 2047, 0, 0, 8'h00, 0, 0, 0, 0);
        issue(1, 3, 5, -6, 0, 8'h00, 0, 0, 0, 0);
        issue(1, 3, 0, -1, 0, 8'h00, 0, 0, 0, 0);
        // R4 indirect with high Z bits set
        issue(1, 2, 10, 0, 0, 8'h00, 16'hF123, 0, 0, 0);
        issue(1, 4, 2047, 0, 0, 8'h00, 16'h0456, 0, 0, 0);
        // R6 return and interrupt return back to back
        issue(1, 6, 30, 0, 0, 8'h00, 0, 0, 0, 1234);
        issue(1, 6, 31, 0, 0, 8'h00, 0, 0, 0, 77);
        issue(1, 5, 32, 0, 0, 8'h00, 0, 0, 0, 500);
        issue(0, 6, 33, 0, 0, 8'h00, 0, 0, 0, 600);   // R2 idle holds
        // R7 branch set/clear taken and not taken
        issue(1, 7, 200, -50, 1, 8'h02, 0, 0, 0, 0);
        issue(1, 7, 200, -50, 1, 8'h00, 0, 0, 0, 0);
        issue(1, 8, 300, 63, 0, 8'h00, 0, 0, 0, 0);
        issue(1, 8, 300, 63, 0, 8'h01, 0, 0, 0, 0);
        // R8 signed compare ignores stored bit 4
        issue(1, 7, 400, 9, 4, 8'h04, 0, 0, 0, 0);
        issue(1, 7, 400, 9, 4, 8'h1C, 0, 0, 0, 0);
        issue(1, 8, 400, 9, 4, 8'h10, 0, 0, 0, 0);
        issue(1, 8, 400, 9, 4, 8'h08, 0, 0, 0, 0);
        // R9 skip variants with wrap
        issue(1, 9, 50, 0, 0, 8'h00, 0, 0, 1, 0);
        issue(1, 9, 50, 0, 0, 8'h00, 0, 1, 0, 0);
        issue(1, 9, 2046, 0, 0, 8'h00, 0, 1, 1, 0);
        issue(1, 9, 2047, 0, 0, 8'h00, 0, 1, 0, 0);
        // R10 ordinary and unused codes
        issue(1, 0, 2047, 5, 0, 8'hFF, 0, 1, 1, 9);
        issue(1, 13, 70, 5, 0, 8'hFF, 0, 1, 1, 9);

        for (int n = 0; n < 4000; n++) begin
            issue(($urandom % 5) != 0, int'($urandom % 16), int'($urandom % 2048),
                  int'($urandom % 4096) - 2048, int'($urandom % 8), 8'($urandom),
                  int'($urandom % 65536), 1'($urandom), 1'($urandom),
                  int'($urandom % 2048));
        end
        issue(0, 0, 0, 0, 0, 8'h00, 0, 0, 0, 0);
        @(negedge clk);
        check_all();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule